// File: doc/BRIEF.md
# Reload-and-Match Timer PWM Generator

This block is an up-counting timer that drives one pulse-width-modulated pin. The counter climbs toward the all-ones value. When it wraps, it restarts from a programmed reload value. Two events toggle the output:

- the wrap (overflow) event, which marks the start of a period;
- an equality match against a compare register, which marks the change of level inside the period.

The reload value therefore sets the period, and the compare value sets where the level changes. A prescaler with a power-of-two divider can slow the count.

Software programs the block through a simple synchronous write port. Each write addresses one of four registers: control, reload, compare or counter. A typical start sequence is:

1. With the timer halted, write the reload and compare values.
2. Seed the counter with all-ones minus one.
3. Set the run bit.

The seed makes the first overflow, and so the first toggle, arrive on the second counter tick. Software stops the timer before it changes any setting. While halted, the pin rests at the level chosen by the polarity bit and the counter keeps its value.

Top module: `reload_match_pwm`

## Requirements
- R1: After reset, `pwm_o` is 0, `count_o` is 0 and every register is 0 (halted, no prescaling, non-inverted, triggers off).
- R2: Write addresses: 0 = control, 1 = reload, 2 = compare, 3 = counter. The control fields are:
  - bit 0: run
  - bit 1: auto-reload
  - bit 2: compare enable
  - bit 3: invert
  - bits 5:4: trigger select
  - bit 6: prescaler enable
  - bits 9:7: prescaler exponent
- R3: While running, each tick adds one to the counter. On a tick at all-ones, the counter loads the reload value when auto-reload is set.
- R4: Trigger select: 0 = no toggling, 1 = toggle on overflow only, 2 or 3 = toggle on overflow and on compare match. An overflow tick toggles the output in every non-zero trigger mode.
- R5: A tick with the counter equal to the compare value toggles the output when compare enable is set and trigger select is 2 or 3. An overflow and a match on the same tick give a single toggle.
- R6: With seed S = all-ones minus one, reload L and compare M (L < M), the sequence is:
  - the first edge comes on tick 2 and goes to the active level;
  - the output then stays active for M-L+1 ticks and inactive for all-ones minus M ticks;
  - the period is 2^32 - L ticks.
- R7: When the compare value is not above the reload value and below the seed, the output toggles only on overflow, with a period of 2^32 - L ticks.
- R8: With the prescaler enabled and exponent f, a tick occurs every 2^(f+1) clocks, the first one 2^(f+1) clocks after run takes effect. With the prescaler disabled, every running clock is a tick.
- R9: One clock after a stop takes effect, the output shows the idle level (the invert bit) and the counter holds its value.
- R10: The invert bit flips the level of the whole waveform, idle level included. A change made while halted appears on the output one clock after the write.
- R11: A counter write loads its value on that clock edge and takes priority over a tick in the same cycle. A match on the written value is detected on the following tick.
- R12: With auto-reload clear, an overflow tick sets the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | 1 | Registered PWM output |
| count_o | output | CNT_W | Current counter value |

## Verification
Two pairs of functions can land in the same cycle, and the bench provokes both.

- **Overflow and match.** The compare value is set to all-ones, so the match and the overflow fall on the same tick. The bench then expects exactly one edge per overflow and no extra edges.
- **Counter write and tick.** The counter is written while the timer runs, so the write meets a live tick. The bench expects three things: the written value appears on `count_o` with no increment, the match on that value produces an edge on the next clock, and the following overflow comes at the cycle computed from the written value.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_LOAD  = 2'd1,
    A_MATCH = 2'd2,
    A_COUNT = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    TRIG_OFF      = 2'd0,
    TRIG_OVF      = 2'd1,
    TRIG_BOTH     = 2'd2,
    TRIG_BOTH_ALT = 2'd3
  } trig_e;

  localparam int PRE_W = 3;

  // field order is the control word layout, MSB first
  typedef struct packed {
    logic [PRE_W-1:0] pre_exp;
    logic             pre_en;
    trig_e            trig;
    logic             invert;
    logic             cmp_en;
    logic             auto_rl;
    logic             run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
  import tpwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] match_val,
  output logic             cnt_wr
);

  logic ctrl_sel, load_sel, match_sel;

  always_comb begin
    ctrl_sel  = wr_en && (reg_addr_e'(wr_addr) == A_CTRL);
    load_sel  = wr_en && (reg_addr_e'(wr_addr) == A_LOAD);
    match_sel = wr_en && (reg_addr_e'(wr_addr) == A_MATCH);
    cnt_wr    = wr_en && (reg_addr_e'(wr_addr) == A_COUNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      load_val  <= '0;
      match_val <= '0;
    end else begin
      if (ctrl_sel)  ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (load_sel)  load_val  <= wr_data;
      if (match_sel) match_val <= wr_data;
    end
  end

endmodule

// File: rtl/tpwm_prescale.sv
module tpwm_prescale #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_en,
  input  logic [EXP_W-1:0] pre_exp,
  output logic             tick
);

  localparam int PC_W = 2 ** EXP_W;

  logic [PC_W-1:0]  pcnt;
  logic [PC_W-1:0]  wrap_at;
  logic [EXP_W:0]   shamt;

  always_comb begin
    shamt   = {1'b0, pre_exp} + {{EXP_W{1'b0}}, 1'b1};
    wrap_at = ~({PC_W{1'b1}} << shamt);
    tick    = run && (!pre_en || (pcnt == wrap_at));
  end

  always_ff @(posedge clk) begin
    if (rst || !run || !pre_en) begin
      pcnt <= '0;
    end else if (pcnt == wrap_at) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

endmodule

// File: rtl/tpwm_counter.sv
module tpwm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             auto_rl,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             match_evt
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic live;
  logic at_top;

  always_comb begin
    live      = tick && !cnt_wr;
    at_top    = (cnt == TOP);
    ovf_evt   = live && at_top;
    match_evt = live && cmp_en && (cnt == match_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= cnt_wdata;
    end else if (tick) begin
      if (at_top) cnt <= auto_rl ? load_val : '0;
      else        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tpwm_outstage.sv
module tpwm_outstage
  import tpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  logic  invert,
  input  trig_e trig,
  input  logic  ovf_evt,
  input  logic  match_evt,
  output logic  pwm_o
);

  logic phase;
  logic phase_d;
  logic flip;

  always_comb begin
    flip = (ovf_evt && (trig != TRIG_OFF)) ||
           (match_evt && ((trig == TRIG_BOTH) || (trig == TRIG_BOTH_ALT)));
    phase_d = run ? (phase ^ flip) : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      pwm_o <= 1'b0;
    end else begin
      phase <= phase_d;
      pwm_o <= invert ^ phase_d;
    end
  end

endmodule

// File: rtl/reload_match_pwm.sv
module reload_match_pwm
  import tpwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_o,
  output logic [CNT_W-1:0] count_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] match_val;
  logic             cnt_wr;
  logic             tick;
  logic             ovf_evt;
  logic             match_evt;
  logic             run_q;
  logic             inv_q;
  logic             arl_q;

  assign run_q = ctrl.run;
  assign inv_q = ctrl.invert;
  assign arl_q = ctrl.auto_rl;

  tpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctrl      (ctrl),
    .load_val  (load_val),
    .match_val (match_val),
    .cnt_wr    (cnt_wr)
  );

  tpwm_prescale #(.EXP_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .pre_en  (ctrl.pre_en),
    .pre_exp (ctrl.pre_exp),
    .tick    (tick)
  );

  tpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (wr_data),
    .auto_rl   (arl_q),
    .cmp_en    (ctrl.cmp_en),
    .load_val  (load_val),
    .match_val (match_val),
    .cnt       (count_o),
    .ovf_evt   (ovf_evt),
    .match_evt (match_evt)
  );

  tpwm_outstage u_out (
    .clk       (clk),
    .rst       (rst),
    .run       (run_q),
    .invert    (inv_q),
    .trig      (ctrl.trig),
    .ovf_evt   (ovf_evt),
    .match_evt (match_evt),
    .pwm_o     (pwm_o)
  );

endmodule

// File: rtl/tpwm_chk.sv
module tpwm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             run_q,
  input logic             inv_q,
  input logic             arl_q,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_val,
  input logic             ovf_evt,
  input logic             match_evt,
  input logic             pwm_o
);

  logic cw;
  assign cw = wr_en && (wr_addr == 2'd3);

  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (pwm_o == $past(inv_q)));

  // R9
  hold_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cw) |=> $stable(cnt));

  // R11
  count_write_chk: assert property (@(posedge clk) disable iff (rst)
    cw |=> (cnt == $past(wr_data)));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cw && (cnt == {CNT_W{1'b1}}) && arl_q) |=> (cnt == $past(load_val)));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cw && (cnt != {CNT_W{1'b1}})) |=> (cnt == $past(cnt) + 1'b1));

  // R5
  quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !ovf_evt && !match_evt && $stable(inv_q)) |=> $stable(pwm_o));

endmodule

bind reload_match_pwm tpwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .run_q     (run_q),
  .inv_q     (inv_q),
  .arl_q     (arl_q),
  .tick      (tick),
  .cnt       (count_o),
  .load_val  (load_val),
  .ovf_evt   (ovf_evt),
  .match_evt (match_evt),
  .pwm_o     (pwm_o)
);

// File: tb/test_reload_match_pwm.sv
module test_reload_match_pwm;

  localparam int CNT_W = 32;
  localparam logic [31:0] SEED = 32'hFFFF_FFFE;
  localparam logic [31:0] LD   = 32'hFFFF_FFF0;
  localparam logic [31:0] MT   = 32'hFFFF_FFF8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             pwm_o;
  logic [CNT_W-1:0] count_o;

  reload_match_pwm #(.CNT_W(CNT_W)) i_reload_match_pwm (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_o   (pwm_o),
    .count_o (count_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    at;
    logic  lvl;
    string tag;
  } edge_t;

  edge_t q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    last_wr = 0;
  logic  last_pwm = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] cw(bit run, bit ar, bit ce, bit inv,
                                     logic [1:0] trig, bit pe, logic [2:0] pexp);
    return {22'd0, pexp, pe, trig, inv, ce, ar, run};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic want(int at, logic lvl, string tag);
    edge_t e;
    e.at = at; e.lvl = lvl; e.tag = tag;
    q.push_back(e);
  endtask

  // called at a falling edge; write happens on the next rising edge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    last_wr = cyc;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // scoreboard monitor: every output change must match the queue head
  always @(negedge clk) begin
    if (!rst && (pwm_o !== last_pwm)) begin
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected edge: actual cycle %0d level %0b expected no edge",
                 cyc, pwm_o);
      end else begin
        edge_t e;
        e = q.pop_front();
        if (e.at != cyc || e.lvl !== pwm_o) begin
          n_bad++;
          $display("FAIL %s: actual cycle %0d level %0b expected cycle %0d level %0b",
                   e.tag, cyc, pwm_o, e.at, e.lvl);
        end
      end
      last_pwm = pwm_o;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pwm_o == 1'b0, "R1 pwm", {31'd0, pwm_o}, 32'd0);
    chk(count_o == 0, "R1 count", count_o, 32'd0);

    // R6 R3 R4 R5 R2: basic period and duty
    wr(2'd1, LD);
    wr(2'd2, MT);
    wr(2'd3, SEED);
    wr(2'd0, cw(1, 1, 1, 0, 2'd2, 0, 3'd0));
    e = last_wr;
    want(e + 2,  1'b1, "R6 first");
    want(e + 11, 1'b0, "R6 match");
    want(e + 18, 1'b1, "R6 period");
    want(e + 27, 1'b0, "R5 match2");
    want(e + 34, 1'b1, "R3 reload");
    wait_until(e + 35);
    wr(2'd0, cw(0, 1, 1, 0, 2'd2, 0, 3'd0));
    want(e + 37, 1'b0, "R9 idle");
    repeat (4) @(negedge clk);
    chk(count_o == 32'hFFFF_FFF2, "R9 hold", count_o, 32'hFFFF_FFF2);
    repeat (4) @(negedge clk);
    chk(count_o == 32'hFFFF_FFF2, "R9 hold2", count_o, 32'hFFFF_FFF2);

    // R10 invert
    wr(2'd3, SEED);
    wr(2'd0, cw(0, 1, 1, 1, 2'd2, 0, 3'd0));
    want(last_wr + 1, 1'b1, "R10 idle high");
    repeat (2) @(negedge clk);
    wr(2'd0, cw(1, 1, 1, 1, 2'd2, 0, 3'd0));
    e = last_wr;
    want(e + 2,  1'b0, "R10 first");
    want(e + 11, 1'b1, "R10 match");
    want(e + 18, 1'b0, "R10 period");
    wait_until(e + 19);
    wr(2'd0, cw(0, 1, 1, 1, 2'd2, 0, 3'd0));
    want(e + 21, 1'b1, "R10 stop");
    repeat (2) @(negedge clk);
    wr(2'd0, cw(0, 1, 1, 0, 2'd2, 0, 3'd0));
    want(last_wr + 1, 1'b0, "R10 clear");
    repeat (2) @(negedge clk);

    // R8 prescaler divide by 4
    wr(2'd3, SEED);
    wr(2'd0, cw(1, 1, 1, 0, 2'd2, 1, 3'd1));
    e = last_wr;
    want(e + 8,  1'b1, "R8 first");
    want(e + 44, 1'b0, "R8 match");
    want(e + 72, 1'b1, "R8 period");
    wait_until(e + 73);
    wr(2'd0, cw(0, 1, 1, 0, 2'd2, 1, 3'd1));
    want(e + 75, 1'b0, "R8 stop");
    repeat (2) @(negedge clk);

    // R7 compare below reload
    wr(2'd2, 32'd5);
    wr(2'd3, SEED);
    wr(2'd0, cw(1, 1, 1, 0, 2'd2, 0, 3'd0));
    e = last_wr;
    want(e + 2,  1'b1, "R7 first");
    want(e + 18, 1'b0, "R7 ovf only");
    want(e + 34, 1'b1, "R7 ovf only2");
    wait_until(e + 35);
    wr(2'd0, cw(0, 1, 1, 0, 2'd2, 0, 3'd0));
    want(e + 37, 1'b0, "R7 stop");
    repeat (2) @(negedge clk);

    // R4 overflow-only trigger ignores a reachable match
    wr(2'd2, MT);
    wr(2'd3, SEED);
    wr(2'd0, cw(1, 1, 1, 0, 2'd1, 0, 3'd0));
    e = last_wr;
    want(e + 2,  1'b1, "R4 first");
    want(e + 18, 1'b0, "R4 ovf only");
    wait_until(e + 19);
    wr(2'd0, cw(0, 1, 1, 0, 2'd1, 0, 3'd0));
    repeat (2) @(negedge clk);

    // R5 overflow and match on the same tick
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, SEED);
    wr(2'd0, cw(1, 1, 1, 0, 2'd2, 0, 3'd0));
    e = last_wr;
    want(e + 2,  1'b1, "R5 coincide");
    want(e + 18, 1'b0, "R5 coincide2");
    wait_until(e + 19);
    wr(2'd0, cw(0, 1, 1, 0, 2'd2, 0, 3'd0));
    repeat (2) @(negedge clk);

    // R11 counter write while running
    wr(2'd2, MT);
    wr(2'd3, SEED);
    wr(2'd0, cw(1, 1, 1, 0, 2'd2, 0, 3'd0));
    e = last_wr;
    want(e + 2, 1'b1, "R11 first");
    wait_until(e + 4);
    wr(2'd3, MT);
    chk(count_o == MT, "R11 write wins", count_o, MT);
    want(e + 6,  1'b0, "R11 match on written");
    want(e + 13, 1'b1, "R11 overflow");
    wait_until(e + 13);
    chk(count_o == LD, "R11 reload", count_o, LD);
    wait_until(e + 14);
    wr(2'd0, cw(0, 1, 1, 0, 2'd2, 0, 3'd0));
    want(e + 16, 1'b0, "R11 stop");
    repeat (2) @(negedge clk);

    // R12 no auto-reload
    wr(2'd3, SEED);
    wr(2'd0, cw(1, 0, 0, 0, 2'd1, 0, 3'd0));
    e = last_wr;
    want(e + 2, 1'b1, "R12 first");
    wait_until(e + 2);
    chk(count_o == 0, "R12 zero", count_o, 32'd0);
    wait_until(e + 3);
    chk(count_o == 1, "R12 count on", count_o, 32'd1);
    wr(2'd0, cw(0, 0, 0, 0, 2'd1, 0, 3'd0));
    want(e + 5, 1'b0, "R12 stop");
    repeat (4) @(negedge clk);

    chk(q.size() == 0, "R6 missing edges", q.size(), 32'd0);
    finish_run();
  end

endmodule